// File: doc/BRIEF.md
# Ticket Lock Arbitration Unit

A single hardware lock that hands out access in strict arrival order. Each requester owns a take-ticket input and a release input. A take-ticket request performs an atomic fetch-and-increment on an internal next-ticket counter. The requester receives the counter value from before the increment and the unit keeps it. A second counter, the serving counter, counts completed releases and is broadcast on every cycle. A requester owns the lock while the ticket it holds equals the serving counter. The unit drives a per-requester grant bit for that condition.

When several requesters take tickets in the same cycle, they receive consecutive numbers in ascending requester-index order. Both counters wrap modulo 2^TW. The parameters must keep the number of outstanding tickets below 2^TW, and NREQ < 2^TW guarantees this. Two misuses have defined behaviour. A release from anyone but the current holder is dropped and sets a sticky error flag. A take from a requester that already holds an outstanding ticket is dropped.

Top module: `tkt_lock_unit`

## Requirements
- R1: After reset, serving_o is 0, held_o is all zero, err_o is 0, and the first accepted ticket is 0.
- R2: A requester with no outstanding ticket that raises take_i is given the next-ticket value before the increment. The ticket appears on its TW-bit slice tkt_o[i*TW +: TW] from the cycle after the request, and next-ticket advances by one per accepted request.
- R3: Requests accepted in the same cycle get consecutive tickets, with the lowest requester index getting the smallest.
- R4: held_o[i] is 1 exactly when requester i has an outstanding ticket equal to serving_o. At most one bit of held_o is set.
- R5: A release from the current holder increments serving_o by one and retires that holder's ticket, both visible in the next cycle.
- R6: Grants follow ticket order: after every holder release, the requester holding the next ticket number is granted.
- R7: A release from a requester whose held_o bit is 0 leaves serving_o unchanged and sets err_o, which stays 1 until reset.
- R8: A take request from a requester that already has an outstanding ticket is ignored: its ticket is unchanged and next-ticket does not advance.
- R9: Both counters wrap modulo 2^TW, so ticket 2^TW-1 is followed by ticket 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | NREQ | Per-requester take-ticket request |
| rel_i | input | NREQ | Per-requester release |
| tkt_o | output | NREQ*TW | Stored ticket per requester, requester i at bits i*TW +: TW |
| held_o | output | NREQ | Per-requester lock grant |
| serving_o | output | TW | Broadcast serving counter |
| err_o | output | 1 | Sticky flag for a release by a non-holder |

## Verification
Every result is registered once. A take sampled at one rising edge shows up on tkt_o and, if it matches, on held_o just after that edge. A release moves serving_o, held_o and err_o at that same edge. The bench drives inputs on the falling edge, removes them 1 ns after the next rising edge, and compares against its arithmetic model at that moment. Each check therefore sees exactly one edge of effect. The sweep walks every non-empty take pattern of four requesters across several counter wraps. After each pattern it drains the lock holder by holder.

// File: rtl/tkt_lock_unit.sv
module tkt_lock_unit #(
  parameter int NREQ = 4,
  parameter int TW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] take_i,
  input  logic [NREQ-1:0] rel_i,
  output logic [NREQ*TW-1:0] tkt_o,
  output logic [NREQ-1:0] held_o,
  output logic [TW-1:0]   serving_o,
  output logic            err_o
);

  logic [TW-1:0]   next_q, serving_q, next_d;
  logic [TW-1:0]   tkt_q [NREQ];
  logic [TW-1:0]   offs  [NREQ];
  logic [NREQ-1:0] vld_q, acc;
  logic            rel_ok, rel_bad, err_q;

  initial begin
    assert (NREQ < (1 << TW)) else $error("NREQ must be below 2**TW");
  end

  assign acc = take_i & ~vld_q;

  always_comb begin
    next_d = next_q;
    for (int i = 0; i < NREQ; i++) begin
      offs[i] = next_d;
      if (acc[i]) next_d = next_d + TW'(1);
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    assign held_o[g]          = vld_q[g] && (tkt_q[g] == serving_q);
    assign tkt_o[g*TW +: TW]  = tkt_q[g];

    // R8: a repeated take leaves the stored ticket alone
    assert_take_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i[g] && vld_q[g]) |=> $stable(tkt_q[g]));
    // R2: an accepted take makes the requester outstanding
    assert_take_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i[g] && !vld_q[g]) |=> vld_q[g]);
  end

  assign rel_ok  = |(rel_i & held_o);
  assign rel_bad = |(rel_i & ~held_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q    <= '0;
      serving_q <= '0;
      vld_q     <= '0;
      err_q     <= 1'b0;
      for (int i = 0; i < NREQ; i++) tkt_q[i] <= '0;
    end else begin
      next_q <= next_d;
      if (rel_ok)  serving_q <= serving_q + TW'(1);
      if (rel_bad) err_q     <= 1'b1;
      for (int i = 0; i < NREQ; i++) begin
        if (acc[i]) begin
          vld_q[i] <= 1'b1;
          tkt_q[i] <= offs[i];
        end else if (rel_i[i] && held_o[i]) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  assign serving_o = serving_q;
  assign err_o     = err_q;

  assert_one_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(held_o));
  assert_release_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> serving_q == $past(serving_q) + TW'(1));
  assert_bad_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_bad && !rel_ok) |=> $stable(serving_q) && err_q);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: tb/tkt_lock_unit_bench.sv
`timescale 1ns/1ps
module tkt_lock_unit_bench;
  localparam int NREQ = 4;
  localparam int TW   = 3;
  localparam int MOD  = 1 << TW;

  logic clk = 1'b0;
  logic rst_n;
  logic [NREQ-1:0] take_i, rel_i;
  logic [NREQ*TW-1:0] tkt_o;
  logic [NREQ-1:0] held_o;
  logic [TW-1:0] serving_o;
  logic err_o;

  int checks = 0;
  int fails  = 0;
  int nxt, srv;
  int et [NREQ];
  bit ev [NREQ];
  bit eerr;

  always #2 clk = ~clk;

  tkt_lock_unit #(.NREQ(NREQ), .TW(TW)) u_tkt_lock_unit (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .rel_i(rel_i),
    .tkt_o(tkt_o), .held_o(held_o), .serving_o(serving_o), .err_o(err_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_held();
    int h = 0;
    for (int i = 0; i < NREQ; i++)
      if (ev[i] && et[i] == srv) h |= (1 << i);
    return h;
  endfunction

  task automatic check_all(input string req);
    check({req, " serving"}, int'(serving_o), srv);
    check({req, " held"}, int'(held_o), exp_held());
    check({req, " err"}, int'(err_o), int'(eerr));
    for (int i = 0; i < NREQ; i++)
      if (ev[i]) check({req, " ticket"}, int'(tkt_o[i*TW +: TW]), et[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; take_i = '0; rel_i = '0;
    @(posedge clk); #1;
    @(negedge clk); rst_n = 1'b1;
    nxt = 0; srv = 0; eerr = 1'b0;
    for (int i = 0; i < NREQ; i++) begin et[i] = 0; ev[i] = 1'b0; end
  endtask

  task automatic take(input int mask, input string req);
    @(negedge clk);
    take_i = NREQ'(mask);
    for (int i = 0; i < NREQ; i++)
      if (mask[i] && !ev[i]) begin
        et[i] = nxt; ev[i] = 1'b1; nxt = (nxt + 1) % MOD;
      end
    @(posedge clk); #1;
    take_i = '0;
    check_all(req);
  endtask

  task automatic release_req(input int mask, input string req);
    int h = exp_held();
    @(negedge clk);
    rel_i = NREQ'(mask);
    if ((mask & ~h) != 0) eerr = 1'b1;
    for (int i = 0; i < NREQ; i++)
      if (mask[i] && h[i]) begin ev[i] = 1'b0; srv = (srv + 1) % MOD; end
    @(posedge clk); #1;
    rel_i = '0;
    check_all(req);
  endtask

  task automatic drain();
    int h;
    h = exp_held();
    while (h != 0) begin
      release_req(h, "R6 fifo handoff");
      h = exp_held();
    end
  endtask

  initial begin
    rst_n = 1'b0; take_i = '0; rel_i = '0;
    do_reset();
    @(posedge clk); #1;
    check_all("R1 reset");

    take(4'b0001, "R2 single take");
    check("R2 ticket0", int'(tkt_o[0 +: TW]), 0);
    take(4'b0100, "R2 second take");
    take(4'b1010, "R3 same-cycle take");
    check("R3 order", int'(tkt_o[1*TW +: TW]), 2);
    check("R3 order", int'(tkt_o[3*TW +: TW]), 3);
    take(4'b0011, "R8 repeated take");
    release_req(4'b0001, "R5 holder release");
    check("R5 serving", int'(serving_o), 1);
    check("R4 holder", int'(held_o), 4'b0100);
    take(4'b0001, "R8 next unchanged");
    check("R8 ticket after ignore", int'(tkt_o[0 +: TW]), 4);
    drain();

    for (int r = 0; r < 3; r++)
      for (int m = 1; m < (1 << NREQ); m++) begin
        take(m, "R9 sweep take");
        drain();
      end

    take(4'b0110, "R7 setup");
    release_req(4'b0100, "R7 non-holder release");
    check("R7 err set", int'(err_o), 1);
    release_req(4'b0000, "R7 err sticky");
    release_req(4'b0110, "R7 holder plus non-holder");
    drain();

    do_reset();
    @(posedge clk); #1;
    check_all("R1 reset again");
    take(4'b1111, "R3 full take after reset");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule